// File: doc/BRIEF.md
# Segmented Converter Switch Decoder

This block turns a 16-bit converter code into the switch controls of a segmented ladder. The upper bits of the code are expanded into a thermometer vector of equally weighted segment switches. The lower bits pass straight through to the binary ladder switches. The coding is straight binary. Code 0000h selects the most negative output, FFFFh selects full scale minus one LSB, and 8000h selects zero volts.

Three conditions override the code and force the zero-volt pattern onto the switches. These are a clear input, a hold window that follows reset release, and the power-down input. The override acts only on the switch outputs. The code arriving at the input is never replaced, so the decode of that code returns on the clock after the last override ends. All switch outputs are registered, so every bit changes on the same clock edge. A separate registered flag tells the analog section to enter its low-power state.

The block has no streaming data path. The code is a level held by the upstream register, so no valid/ready handshake is used and there are no back-pressure rules.

Top module: `segdac_switch_ctrl`

## Requirements
- R1: With no override active, the segment vector `seg_sw` has exactly k bits set, where k is the value of the code's top 4 bits. The set bits are the lowest k bits (bit 0 is the first segment).
- R2: With no override active, `bin_sw` equals code bits [11:0], and bit 11 is the most significant ladder switch.
- R3: A change of `code` shows on all switch outputs on the first rising clock edge after the change, and every output changes on that one edge.
- R4: While `clr_n` is low, the switch outputs take the zero-volt pattern one clock later. That pattern is `seg_sw` = 0x00FF (the lowest 8 segments on) and `bin_sw` = 0.
- R5: Changes to `code` made during a clear do not appear at the outputs. On the first clock after `clr_n` rises, the outputs show the decode of the code present at that clock.
- R6: When `pd_n` is low, `pd_en` is 1 and the switches show the zero-volt pattern, both one clock later. When `pd_n` is high, `pd_en` is 0 one clock later.
- R7: For HOLD_CYCLES (default 8) rising edges after `rst_n` is released, the outputs show the zero-volt pattern whatever the code. On the next edge they show the decode.
- R8: While `rst_n` is low, the outputs show the zero-volt pattern and `pd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code | input | 16 | Converter register code, straight binary |
| clr_n | input | 1 | Active-low clear to zero volts |
| pd_n | input | 1 | Active-low power-down request |
| seg_sw | output | 15 | Thermometer segment switches, bit 0 is the first segment |
| bin_sw | output | 12 | Binary ladder switches, bit 11 is the MSB |
| pd_en | output | 1 | Low-power enable for the analog section |

## Verification
There are two internal states: the hold counter and the output registers. A fault in the hold counter shows at the ports as a zero-volt window that is too short, too long, or never ends. The bench counts the window edge by edge after reset. A fault in the override logic or the decode shows in the outputs one clock after the stimulus, as a wrong segment count, a gap in the thermometer, or a wrong binary field. The exhaustive sweep of all codes with one-clock sampling finds such a fault on the first code that exposes it.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int DEF_CODE_W   = 16;
  localparam int DEF_SEG_BITS = 4;
  localparam int DEF_HOLD     = 8;

  // Count of segments that are on at the bipolar-zero (midscale) code
  function automatic int midscale_segs(input int seg_bits);
    return 1 << (seg_bits - 1);
  endfunction
endpackage

// File: rtl/segdac_thermo.sv
module segdac_thermo #(
  parameter int SEG_BITS = 4,
  localparam int SEG_N = (1 << SEG_BITS) - 1
) (
  input  logic [SEG_BITS-1:0] top,
  output logic [SEG_N-1:0]    therm
);
  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign therm[i] = (top > SEG_BITS'(i));
  end
endmodule

// File: rtl/segdac_por_hold.sv
module segdac_por_hold #(
  parameter int HOLD_CYCLES = 8,
  localparam int CW = $clog2(HOLD_CYCLES + 1) < 1 ? 1 : $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic hold
);
  logic [CW-1:0] cnt;

  assign hold = (cnt != CW'(HOLD_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (hold) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/segdac_switch_ctrl.sv
module segdac_switch_ctrl
  import segdac_pkg::*;
#(
  parameter int CODE_W      = DEF_CODE_W,
  parameter int SEG_BITS    = DEF_SEG_BITS,
  parameter int HOLD_CYCLES = DEF_HOLD,
  localparam int SEG_N = (1 << SEG_BITS) - 1,
  localparam int BIN_W = CODE_W - SEG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              clr_n,
  input  logic              pd_n,
  output logic [SEG_N-1:0]  seg_sw,
  output logic [BIN_W-1:0]  bin_sw,
  output logic              pd_en
);
  localparam int MID_SEGS = midscale_segs(SEG_BITS);
  localparam logic [SEG_N-1:0] ZERO_SEG = SEG_N'((1 << MID_SEGS) - 1);

  logic             por_hold;
  logic             force_zero;
  logic [SEG_N-1:0] therm;

  segdac_thermo #(.SEG_BITS(SEG_BITS)) u_thermo (
    .top   (code[CODE_W-1 -: SEG_BITS]),
    .therm (therm)
  );

  segdac_por_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (por_hold)
  );

  assign force_zero = !clr_n || !pd_n || por_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_sw <= ZERO_SEG;
      bin_sw <= '0;
      pd_en  <= 1'b0;
    end else begin
      seg_sw <= force_zero ? ZERO_SEG : therm;
      bin_sw <= force_zero ? '0 : code[BIN_W-1:0];
      pd_en  <= !pd_n;
    end
  end
endmodule

// File: rtl/segdac_switch_ctrl_chk.sv
module segdac_switch_ctrl_chk #(
  parameter int CODE_W   = 16,
  parameter int SEG_BITS = 4,
  localparam int SEG_N = (1 << SEG_BITS) - 1,
  localparam int BIN_W = CODE_W - SEG_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code,
  input logic              clr_n,
  input logic              pd_n,
  input logic              por_hold,
  input logic [SEG_N-1:0]  seg_sw,
  input logic [BIN_W-1:0]  bin_sw,
  input logic              pd_en
);
  localparam logic [SEG_N-1:0] ZSEG = SEG_N'((1 << (1 << (SEG_BITS - 1))) - 1);

  // R1: segment vector always a contiguous run from bit 0
  a_r1_thermo_contig: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_sw + SEG_N'(1)) & seg_sw) == '0);

  // R2: binary field follows low code bits when no override
  a_r2_bin_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && pd_n && !por_hold) |=> (bin_sw == $past(code[BIN_W-1:0])));

  // R4: clear forces the zero-volt pattern
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (seg_sw == ZSEG && bin_sw == '0));

  // R6: power-down flag tracks the request
  a_r6_pd_on: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (pd_en && seg_sw == ZSEG && bin_sw == '0));
  a_r6_pd_off: assert property (@(posedge clk) disable iff (!rst_n)
    pd_n |=> !pd_en);

  // R7: power-on hold forces the zero-volt pattern
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    por_hold |=> (seg_sw == ZSEG && bin_sw == '0));
endmodule

bind segdac_switch_ctrl segdac_switch_ctrl_chk #(
  .CODE_W(CODE_W), .SEG_BITS(SEG_BITS)
) u_chk (.*);

// File: tb/segdac_switch_ctrl_tb.sv
module segdac_switch_ctrl_tb;
  localparam int HOLD = 8;
  localparam logic [14:0] ZSEG = 15'h00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] code = 16'hFFFF;
  logic        clr_n = 1'b1;
  logic        pd_n = 1'b1;
  logic [14:0] seg_sw;
  logic [11:0] bin_sw;
  logic        pd_en;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  segdac_switch_ctrl #(.CODE_W(16), .SEG_BITS(4), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .code(code), .clr_n(clr_n), .pd_n(pd_n),
    .seg_sw(seg_sw), .bin_sw(bin_sw), .pd_en(pd_en)
  );

  function automatic logic [14:0] exp_seg(input logic [15:0] c);
    return 15'((32'd1 << c[15:12]) - 1);
  endfunction

  task automatic chk(input string req, input logic [14:0] es,
                     input logic [11:0] eb, input logic ep);
    checks++;
    if (seg_sw !== es || bin_sw !== eb || pd_en !== ep) begin
      errors++;
      $display("FAIL %s seg=%h bin=%h pd=%b expected seg=%h bin=%h pd=%b",
               req, seg_sw, bin_sw, pd_en, es, eb, ep);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", ZSEG, 12'h000, 1'b0);
    rst_n = 1'b1;
    for (int k = 1; k <= HOLD; k++) begin
      @(negedge clk);
      chk("R7", ZSEG, 12'h000, 1'b0);
    end
    @(negedge clk);
    chk("R7", exp_seg(16'hFFFF), 12'hFFF, 1'b0);

    // R1 R2 R3: exhaustive sweep, one-clock latency
    for (int c = 0; c < 65536; c++) begin
      code = 16'(c);
      @(negedge clk);
      chk("R1/R2/R3", exp_seg(code), code[11:0], 1'b0);
    end

    // R4 and R5
    code = 16'h1234;
    @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    chk("R4", ZSEG, 12'h000, 1'b0);
    code = 16'hABCD;
    @(negedge clk);
    chk("R4", ZSEG, 12'h000, 1'b0);
    clr_n = 1'b1;
    @(negedge clk);
    chk("R5", exp_seg(16'hABCD), 12'hBCD, 1'b0);

    // R6
    code = 16'h0F0F;
    pd_n = 1'b0;
    @(negedge clk);
    chk("R6", ZSEG, 12'h000, 1'b1);
    pd_n = 1'b1;
    @(negedge clk);
    chk("R6", exp_seg(16'h0F0F), 12'hF0F, 1'b0);

    // R8 again mid-run, then hold restarts (R7)
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8", ZSEG, 12'h000, 1'b0);
    rst_n = 1'b1;
    repeat (HOLD) @(negedge clk);
    chk("R7", ZSEG, 12'h000, 1'b0);
    @(negedge clk);
    chk("R7", exp_seg(16'h0F0F), 12'hF0F, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule